// File: doc/BRIEF.md
# Programmable Periodic Interrupt Divider

This block derives a periodic event from a 32.768 kHz timebase delivered as a one-cycle tick enable in the system clock domain. A free-running 15-bit count advances on every tick. A 4-bit rate selector picks a power-of-two period, and a separate enable gates the output. The output is a single system-clock pulse that marks each period boundary. Downstream flag and interrupt logic consumes this pulse.

Events are aligned to the free-running count rather than to the moment of configuration. The first event after the block is enabled, or after its rate changes, falls on the next multiple of the selected period. The count keeps running while the block is disabled. Because every decision uses the current selector and enable, a reconfiguration is simply seen at the next tick.

Top module: `periodic_irq_divider`

## Requirements
- R1: While reset is asserted and after its release, the pulse is low and the internal count starts at zero. With no reconfiguration, the first event comes at the tick that brings the count to one full period.
- R2: A rate selector value of 0 never produces a pulse, whatever the enable and tick activity.
- R3: While the enable input is low, no pulse is produced for any rate selector value.
- R4: For selector values 3 to 15, the period is 2^(value-1) ticks. Value 3 gives 4 ticks and value 15 gives 16384 ticks.
- R5: Selector values 1 and 2 alias to values 8 and 9, giving periods of 128 and 256 ticks.
- R6: A pulse is produced exactly at a tick that makes the free-running count a multiple of the period. The count advances on every tick, including while the block is disabled.
- R7: The pulse is one system clock wide. It appears on the clock edge that samples the tick, and never on an edge without a tick.
- R8: A rate change takes effect at the next boundary of the new period on the running count, with no restart of the count.
- R9: The count wraps from 32767 to 0, and the wrap tick is a boundary for every period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle enable at the 32.768 kHz rate |
| rate_sel | input | 4 | Rate selector (0 = off, 1/2 aliased, 3..15 = 2^(n-1) ticks) |
| periodic_en | input | 1 | Periodic event enable |
| periodic_pulse | output | 1 | One-cycle periodic event |

## Verification
Each pulse is registered: it becomes visible right after the rising edge that samples the tick, in the same edge that advances the count. The bench raises the tick at a falling edge and samples the pulse at the next falling edge, one edge after the decision. It samples again one cycle later to confirm the pulse has already dropped. A bench model counts the ticks it issued and predicts each pulse from the selector and enable that were held during that tick.

// File: rtl/pid_pkg.sv
package pid_pkg;
  localparam int CNT_W     = 15;
  localparam int CODE_W    = 4;
  localparam int ALIAS_MAX = 2;
  localparam int ALIAS_OFS = 7;

  // Fold the low selector values onto their aliased codes.
  function automatic logic [CODE_W-1:0] eff_code(input logic [CODE_W-1:0] sel);
    if (sel != '0 && sel <= CODE_W'(ALIAS_MAX))
      return sel + CODE_W'(ALIAS_OFS);
    return sel;
  endfunction

  // Boundary mask: low (code-1) bits set.
  function automatic logic [CNT_W-1:0] period_mask(input logic [CODE_W-1:0] code);
    logic [CNT_W-1:0] one;
    one = CNT_W'(1);
    if (code == '0)
      return '0;
    return (one << (code - CODE_W'(1))) - one;
  endfunction
endpackage

// File: rtl/pid_tick_counter.sv
module pid_tick_counter #(
  parameter int CNT_W = pid_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt
);
  // Free-running; wraps naturally at 2^CNT_W.
  assign cnt_nxt = cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (tick_en) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/pid_rate_decode.sv
module pid_rate_decode #(
  parameter int CNT_W  = pid_pkg::CNT_W,
  parameter int CODE_W = pid_pkg::CODE_W
) (
  input  logic [CODE_W-1:0] rate_sel,
  input  logic              periodic_en,
  output logic              active,
  output logic [CNT_W-1:0]  mask
);
  logic [CODE_W-1:0] code;

  always_comb begin
    code   = pid_pkg::eff_code(rate_sel);
    mask   = pid_pkg::period_mask(code);
    active = periodic_en && (rate_sel != '0);
  end
endmodule

// File: rtl/pid_event_gen.sv
module pid_event_gen #(
  parameter int CNT_W = pid_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             active,
  input  logic [CNT_W-1:0] mask,
  input  logic [CNT_W-1:0] cnt_nxt,
  output logic             fire,
  output logic             pulse_q
);
  // Boundary when the count about to be stored has its masked bits clear.
  assign fire = tick_en && active && ((cnt_nxt & mask) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= fire;
  end
endmodule

// File: rtl/periodic_irq_divider.sv
module periodic_irq_divider #(
  parameter int CNT_W  = pid_pkg::CNT_W,
  parameter int CODE_W = pid_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [CODE_W-1:0] rate_sel,
  input  logic              periodic_en,
  output logic              periodic_pulse
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] rate_mask;
  logic             rate_active;
  logic             boundary_fire;

  pid_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt)
  );

  pid_rate_decode #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_dec (
    .rate_sel(rate_sel), .periodic_en(periodic_en),
    .active(rate_active), .mask(rate_mask)
  );

  pid_event_gen #(.CNT_W(CNT_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .active(rate_active), .mask(rate_mask), .cnt_nxt(cnt_nxt),
    .fire(boundary_fire), .pulse_q(periodic_pulse)
  );
endmodule

// File: rtl/pid_checker.sv
module pid_checker #(
  parameter int CNT_W  = pid_pkg::CNT_W,
  parameter int CODE_W = pid_pkg::CODE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic [CODE_W-1:0] rate_sel,
  input logic              periodic_en,
  input logic              periodic_pulse,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  mask
);
  assert_pulse_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    periodic_pulse |=> !periodic_pulse);

  assert_pulse_needs_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    periodic_pulse |-> $past(tick_en));

  assert_code_zero_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    periodic_pulse |-> ($past(rate_sel) != '0));

  assert_enable_gates_R3: assert property (@(posedge clk) disable iff (!rst_n)
    periodic_pulse |-> $past(periodic_en));

  assert_aligned_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    periodic_pulse |-> ((cnt & $past(mask)) == '0));

  assert_alias_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (periodic_pulse && $past(rate_sel) == CODE_W'(1)) |-> (cnt[6:0] == 7'd0));

  assert_count_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt));
endmodule

bind periodic_irq_divider pid_checker #(.CNT_W(CNT_W), .CODE_W(CODE_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rate_sel(rate_sel),
  .periodic_en(periodic_en), .periodic_pulse(periodic_pulse),
  .cnt(cnt_q), .mask(rate_mask)
);

// File: tb/test_periodic_irq_divider.sv
module test_periodic_irq_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic       periodic_en = 1'b0;
  logic       periodic_pulse;

  int total = 0;
  int fails = 0;
  int m_cnt = 0;
  int seen  = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  periodic_irq_divider i_periodic_irq_divider (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rate_sel(rate_sel),
    .periodic_en(periodic_en), .periodic_pulse(periodic_pulse)
  );

  function automatic int period_of(input int code);
    int c;
    c = (code == 1 || code == 2) ? code + 7 : code;
    return (2 ** c) / 2;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: pulse=%0b expected=%0b (count=%0d)", tag, act, exp, m_cnt);
    end
  endtask

  // One tick: raise on a falling edge, sample one edge after the deciding rising edge.
  task automatic do_tick(input string tag);
    logic exp;
    @(negedge clk);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
    m_cnt = (m_cnt + 1) % 32768;
    exp = periodic_en && rate_sel != 0 && (m_cnt % period_of(rate_sel)) == 0;
    check(tag, periodic_pulse, exp);
    if (exp) begin
      seen++;
      @(negedge clk);
      check("R7", periodic_pulse, 1'b0);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", periodic_pulse, 1'b0);
    rst_n = 1'b1;
    m_cnt = 0;
    rate_sel = 4'd3; periodic_en = 1'b1;
    for (int i = 0; i < 4; i++) do_tick("R1");
    check("R1", seen == 1, 1'b1);
  endtask

  task automatic t_code_zero();
    rate_sel = 4'd0; periodic_en = 1'b1; seen = 0;
    for (int i = 0; i < 40; i++) do_tick("R2");
    check("R2", seen == 0, 1'b1);
  endtask

  task automatic t_enable_off();
    periodic_en = 1'b0; seen = 0;
    for (int c = 3; c < 6; c++) begin
      rate_sel = 4'(c);
      for (int i = 0; i < 20; i++) do_tick("R3");
    end
    check("R3", seen == 0, 1'b1);
  endtask

  task automatic t_rates();
    periodic_en = 1'b1;
    for (int c = 3; c <= 10; c++) begin
      rate_sel = 4'(c); seen = 0;
      for (int i = 0; i < 2 * period_of(c); i++) do_tick("R4");
      check("R4", seen == 2, 1'b1);
    end
  endtask

  task automatic t_alias();
    periodic_en = 1'b1;
    for (int c = 1; c <= 2; c++) begin
      rate_sel = 4'(c); seen = 0;
      for (int i = 0; i < 2 * period_of(c); i++) do_tick("R5");
      check("R5", seen == 2, 1'b1);
    end
  endtask

  task automatic t_rate_change();
    periodic_en = 1'b1;
    rate_sel = 4'd9;
    for (int i = 0; i < 100; i++) do_tick("R8");
    rate_sel = 4'd3; seen = 0;
    for (int i = 0; i < 4; i++) do_tick("R8");
    check("R8", seen == 1, 1'b1);
    periodic_en = 1'b0;
    for (int i = 0; i < 7; i++) do_tick("R6");
    periodic_en = 1'b1; rate_sel = 4'd5;
    for (int i = 0; i < 40; i++) do_tick("R6");
  endtask

  task automatic t_wrap();
    periodic_en = 1'b1; rate_sel = 4'd15; seen = 0;
    while (m_cnt != 32767) do_tick("R4");
    do_tick("R9");
    check("R9", m_cnt == 0 && seen >= 1, 1'b1);
    rate_sel = 4'd3;
    for (int i = 0; i < 8; i++) do_tick("R9");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_code_zero();
    t_enable_off();
    t_rates();
    t_alias();
    t_rate_change();
    t_wrap();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule